// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This core exchanges byte channels between time-division multiplexed streams. Each clock cycle carries one channel time slot. In that slot, every input stream presents one byte and every output stream produces one byte. A frame marker names slot 0. Each input byte is stored in a data memory that has three frame banks. The banks are used in rotation, so each output slot is built from a byte received exactly two frames earlier, whichever slots the source and destination occupy.

Each output stream and slot has a connection word that chooses what is sent. The word can select any stored input channel, or it can carry a constant byte from the processor. The word can also force the slot to all ones or release the line to high impedance. A small processor port reads and writes the connection words. The same port can fill every connection word at once, and it can read back the bytes of the last complete input frame. New connection words are only used from the next frame marker. A frame therefore never mixes old and new settings.

Top module: `tsi_switch_core`

## Requirements
- R1: After reset, every output slot of every stream is released (`tx_oe` low) with `tx_data` zero, `cpu_rdata` is zero, and every connection word reads back as 0x0200 (release bit only) until software writes it.
- R2: A cycle with `frame_sync` high is slot 0. The slot number rises by one per clock and wraps after CHANNELS-1. The output for slot d is registered and appears in the clock after input slot d is sampled.
- R3: A connection word with bit 10 clear selects a source. Bits 6:5 give the source stream and bits 4:0 give the source slot. The output carries that stored input byte.
- R4: A selected byte always comes from the input frame two frames before the output frame. This holds when the source slot is earlier than, later than, or at either end relative to the destination slot.
- R5: A connection word with bit 10 set sends its bits 7:0 as a constant byte.
- R6: Bit 8 drives the slot as 0xFF with `tx_oe` high. It overrides both the constant byte and the selected byte.
- R7: Bit 9 releases the slot (`tx_oe` low, `tx_data` zero). It overrides bit 8.
- R8: A connection word written during frame F first affects output frame F+1. Slots later in frame F still use the previous word.
- R9: The port address is {space[8:7], index[6:0]}. Connection space is 01 with index {stream, slot}. A read returns its word in the clock after the request, and that word reflects writes made before the read.
- R10: Data space is 10 with index {stream, slot}. A read returns the byte received in the previous complete frame. Writes to data space change nothing.
- R11: Register space is 00. Index 0 is a read/write fill pattern. Writing index 1 with bit 0 set copies the pattern into every connection word in one clock. Index 1 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one channel slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High during slot 0 of each frame |
| rx_data | input | STREAMS*8 | Input bytes for the current slot, stream s at [8s+7:8s] |
| tx_data | output | STREAMS*8 | Output bytes, one per stream |
| tx_oe | output | STREAMS | Per-stream drive enable for the current output slot |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Write when high, read when low |
| cpu_addr | input | 9 | Space and index |
| cpu_wdata | input | CPU_DW | Write data |
| cpu_rdata | output | CPU_DW | Read data, valid the clock after a read |

## Verification
A fault in the slot counter or the bank rotation shows up as a byte from the wrong frame or the wrong slot. It is visible on the first checked output slot after the fault. A write that takes effect at the wrong time appears within the same frame, as a changed byte in a slot that follows the write. A priority fault shows up as a driven line where a released line was expected, or as the wrong byte. Readback of the connection and data spaces reveals stored state one clock after the request.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int NUM_BANKS    = 3;
    localparam int BYTE_W       = 8;
    localparam int REG_FILL_PAT = 0;
    localparam int REG_FILL_GO  = 1;

    typedef logic [1:0] bank_t;

    typedef enum logic [1:0] {
        SPACE_REG  = 2'd0,
        SPACE_CONN = 2'd1,
        SPACE_DATA = 2'd2,
        SPACE_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        KIND_CONN,
        KIND_MSG,
        KIND_ONES,
        KIND_HIZ
    } kind_e;

    typedef struct packed {
        logic              oe;
        logic [BYTE_W-1:0] data;
    } tx_slot_t;

    function automatic bank_t bank_inc(bank_t b);
        return (b == bank_t'(NUM_BANKS - 1)) ? bank_t'(0) : b + bank_t'(1);
    endfunction

    // release beats ones, ones beat constant or selected data
    function automatic kind_e slot_kind(logic msg, logic hiz, logic ones);
        if (hiz)       return KIND_HIZ;
        else if (ones) return KIND_ONES;
        else if (msg)  return KIND_MSG;
        else           return KIND_CONN;
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
#(
    parameter int CHANNELS = 32,
    localparam int CW = $clog2(CHANNELS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_sync,
    output logic [CW-1:0] slot,
    output bank_t         wr_bank,
    output bank_t         rd_bank,
    output bank_t         hold_bank
);

    logic [CW-1:0] cnt_q;
    bank_t         bank_q;

    always_comb begin
        slot      = frame_sync ? '0 : cnt_q;
        wr_bank   = frame_sync ? bank_inc(bank_q) : bank_q;
        rd_bank   = bank_inc(wr_bank);
        hold_bank = bank_inc(rd_bank);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bank_q <= '0;
        end else begin
            cnt_q  <= (slot == CW'(CHANNELS - 1)) ? '0 : slot + CW'(1);
            bank_q <= wr_bank;
        end
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 32,
    localparam int SW = $clog2(STREAMS),
    localparam int CW = $clog2(CHANNELS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [CW-1:0]                    wr_slot,
    input  bank_t                            wr_bank,
    input  logic [STREAMS-1:0][BYTE_W-1:0]   wr_bytes,
    input  bank_t                            rd_bank,
    input  logic [STREAMS-1:0][SW-1:0]       rd_strm,
    input  logic [STREAMS-1:0][CW-1:0]       rd_ch,
    output logic [STREAMS-1:0][BYTE_W-1:0]   rd_bytes,
    input  bank_t                            mon_bank,
    input  logic [SW-1:0]                    mon_strm,
    input  logic [CW-1:0]                    mon_ch,
    output logic [BYTE_W-1:0]                mon_byte
);

    logic [BYTE_W-1:0] store [NUM_BANKS][STREAMS][CHANNELS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++)
                for (int s = 0; s < STREAMS; s++)
                    for (int c = 0; c < CHANNELS; c++)
                        store[b][s][c] <= '0;
        end else begin
            for (int s = 0; s < STREAMS; s++)
                store[wr_bank][s][wr_slot] <= wr_bytes[s];
        end
    end

    always_comb begin
        for (int o = 0; o < STREAMS; o++)
            rd_bytes[o] = store[rd_bank][rd_strm[o]][rd_ch[o]];
        mon_byte = store[mon_bank][mon_strm][mon_ch];
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
    import tsi_pkg::*;
#(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 32,
    parameter int CMW      = 11,
    parameter logic [CMW-1:0] RESET_WORD = '0,
    localparam int SW    = $clog2(STREAMS),
    localparam int CW    = $clog2(CHANNELS),
    localparam int IDX_W = SW + CW,
    localparam int DEPTH = STREAMS * CHANNELS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frame_sync,
    input  logic [CW-1:0]                 slot,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [CMW-1:0]                wr_word,
    input  logic                          fill_en,
    input  logic [CMW-1:0]                fill_word,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [CMW-1:0]                rd_word,
    output logic [STREAMS-1:0][CMW-1:0]   slot_words
);

    // staged copy takes software writes, live copy feeds the outputs
    logic [CMW-1:0] staged [DEPTH];
    logic [CMW-1:0] live   [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                staged[i] <= RESET_WORD;
                live[i]   <= RESET_WORD;
            end
        end else begin
            if (fill_en) begin
                for (int i = 0; i < DEPTH; i++)
                    staged[i] <= fill_word;
            end else if (wr_en) begin
                staged[wr_idx] <= wr_word;
            end
            if (frame_sync) begin
                for (int i = 0; i < DEPTH; i++)
                    live[i] <= staged[i];
            end
        end
    end

    assign rd_word = staged[rd_idx];

    for (genvar o = 0; o < STREAMS; o++) begin : g_lookup
        localparam logic [SW-1:0] O_ID = SW'(o);
        logic [IDX_W-1:0] at;
        assign at = {O_ID, slot};
        // on the first slot of a frame the staged copy is already the one in force
        assign slot_words[o] = frame_sync ? staged[at] : live[at];
    end

endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
    import tsi_pkg::*;
#(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 32,
    parameter int CMW      = 11,
    localparam int SW    = $clog2(STREAMS),
    localparam int CW    = $clog2(CHANNELS),
    localparam int PAY_W = CMW - 3
) (
    input  logic [STREAMS-1:0][CMW-1:0]     words,
    input  logic [STREAMS-1:0][BYTE_W-1:0]  src_bytes,
    output logic [STREAMS-1:0][SW-1:0]      src_strm,
    output logic [STREAMS-1:0][CW-1:0]      src_ch,
    output tx_slot_t [STREAMS-1:0]          next_slot
);

    localparam int BIT_ONES = PAY_W;
    localparam int BIT_HIZ  = PAY_W + 1;
    localparam int BIT_MSG  = PAY_W + 2;

    for (genvar o = 0; o < STREAMS; o++) begin : g_stream
        kind_e kind;
        assign src_ch[o]   = words[o][CW-1:0];
        assign src_strm[o] = words[o][CW+SW-1:CW];
        assign kind = slot_kind(words[o][BIT_MSG], words[o][BIT_HIZ], words[o][BIT_ONES]);

        always_comb begin
            unique case (kind)
                KIND_HIZ:  next_slot[o] = '{oe: 1'b0, data: '0};
                KIND_ONES: next_slot[o] = '{oe: 1'b1, data: '1};
                KIND_MSG:  next_slot[o] = '{oe: 1'b1, data: words[o][BYTE_W-1:0]};
                default:   next_slot[o] = '{oe: 1'b1, data: src_bytes[o]};
            endcase
        end
    end

endmodule

// File: rtl/tsi_switch_core.sv
module tsi_switch_core
    import tsi_pkg::*;
#(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 32,
    parameter int CPU_DW   = 16,
    localparam int SW    = $clog2(STREAMS),
    localparam int CW    = $clog2(CHANNELS),
    localparam int SEL_W = SW + CW,
    localparam int PAY_W = (SEL_W > BYTE_W) ? SEL_W : BYTE_W,
    localparam int CMW   = PAY_W + 3,
    localparam int IDX_W = SEL_W,
    localparam int AW    = IDX_W + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_sync,
    input  logic [STREAMS*BYTE_W-1:0] rx_data,
    output logic [STREAMS*BYTE_W-1:0] tx_data,
    output logic [STREAMS-1:0]        tx_oe,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [AW-1:0]             cpu_addr,
    input  logic [CPU_DW-1:0]         cpu_wdata,
    output logic [CPU_DW-1:0]         cpu_rdata
);

    localparam logic [CMW-1:0] RELEASED = CMW'(1) << (PAY_W + 1);

    logic [CW-1:0] cur_slot;
    bank_t         wr_bank, rd_bank, hold_bank;

    logic [STREAMS-1:0][BYTE_W-1:0] rx_bytes;
    logic [STREAMS-1:0][BYTE_W-1:0] src_bytes;
    logic [STREAMS-1:0][SW-1:0]     src_strm;
    logic [STREAMS-1:0][CW-1:0]     src_ch;
    logic [STREAMS-1:0][CMW-1:0]    slot_words;
    tx_slot_t [STREAMS-1:0]         next_slot;
    tx_slot_t [STREAMS-1:0]         tx_q;

    space_e           space;
    logic [IDX_W-1:0] idx;
    logic             cm_wr, fill_go, pat_wr, rd_req;
    logic [CPU_DW-1:0] fill_pat_q;
    logic [CMW-1:0]   cm_rd_word;
    logic [BYTE_W-1:0] dm_rd_byte;

    for (genvar s = 0; s < STREAMS; s++) begin : g_io
        assign rx_bytes[s]              = rx_data[s*BYTE_W +: BYTE_W];
        assign tx_data[s*BYTE_W +: BYTE_W] = tx_q[s].data;
        assign tx_oe[s]                 = tx_q[s].oe;
    end

    tsi_slot_timer #(.CHANNELS(CHANNELS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .slot      (cur_slot),
        .wr_bank   (wr_bank),
        .rd_bank   (rd_bank),
        .hold_bank (hold_bank)
    );

    assign space   = space_e'(cpu_addr[AW-1 -: 2]);
    assign idx     = cpu_addr[IDX_W-1:0];
    assign rd_req  = cpu_req && !cpu_we;
    assign cm_wr   = cpu_req && cpu_we && (space == SPACE_CONN);
    assign pat_wr  = cpu_req && cpu_we && (space == SPACE_REG) && (idx == IDX_W'(REG_FILL_PAT));
    assign fill_go = cpu_req && cpu_we && (space == SPACE_REG) && (idx == IDX_W'(REG_FILL_GO))
                     && cpu_wdata[0];

    tsi_data_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_dmem (
        .clk      (clk),
        .rst      (rst),
        .wr_slot  (cur_slot),
        .wr_bank  (wr_bank),
        .wr_bytes (rx_bytes),
        .rd_bank  (rd_bank),
        .rd_strm  (src_strm),
        .rd_ch    (src_ch),
        .rd_bytes (src_bytes),
        .mon_bank (hold_bank),
        .mon_strm (idx[IDX_W-1:CW]),
        .mon_ch   (idx[CW-1:0]),
        .mon_byte (dm_rd_byte)
    );

    tsi_conn_mem #(
        .STREAMS   (STREAMS),
        .CHANNELS  (CHANNELS),
        .CMW       (CMW),
        .RESET_WORD(RELEASED)
    ) u_cmem (
        .clk       (clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .slot      (cur_slot),
        .wr_en     (cm_wr),
        .wr_idx    (idx),
        .wr_word   (cpu_wdata[CMW-1:0]),
        .fill_en   (fill_go),
        .fill_word (fill_pat_q[CMW-1:0]),
        .rd_idx    (idx),
        .rd_word   (cm_rd_word),
        .slot_words(slot_words)
    );

    tsi_out_sel #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .CMW(CMW)) u_sel (
        .words    (slot_words),
        .src_bytes(src_bytes),
        .src_strm (src_strm),
        .src_ch   (src_ch),
        .next_slot(next_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STREAMS; s++)
                tx_q[s] <= '{oe: 1'b0, data: '0};
        end else begin
            tx_q <= next_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_pat_q <= '0;
            cpu_rdata  <= '0;
        end else begin
            if (pat_wr)
                fill_pat_q <= cpu_wdata;
            if (rd_req) begin
                unique case (space)
                    SPACE_REG:  cpu_rdata <= (idx == IDX_W'(REG_FILL_PAT)) ? fill_pat_q : '0;
                    SPACE_CONN: cpu_rdata <= CPU_DW'(cm_rd_word);
                    SPACE_DATA: cpu_rdata <= CPU_DW'(dm_rd_byte);
                    default:    cpu_rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
    import tsi_pkg::*;
#(
    parameter int STREAMS  = 4,
    parameter int CHANNELS = 32,
    parameter int CPU_DW   = 16,
    localparam int CW = $clog2(CHANNELS)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      frame_sync,
    input logic [STREAMS*BYTE_W-1:0] tx_data,
    input logic [STREAMS-1:0]        tx_oe,
    input logic                      cpu_req,
    input logic                      cpu_we,
    input logic [CPU_DW-1:0]         cpu_rdata,
    input logic [CW-1:0]             cur_slot,
    input bank_t                     wr_bank
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (tx_oe == '0 && tx_data == '0 && cpu_rdata == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_sync && !$past(rst)) |->
            cur_slot == (($past(cur_slot) == CW'(CHANNELS - 1)) ? '0 : $past(cur_slot) + CW'(1)));

    // R4
    bank_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && !$past(rst)) |-> wr_bank == bank_inc($past(wr_bank)));

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_sync && !$past(rst)) |-> $stable(wr_bank));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_req && !cpu_we) |=> $stable(cpu_rdata));

    for (genvar s = 0; s < STREAMS; s++) begin : g_line
        // R7
        released_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !tx_oe[s] |-> tx_data[s*BYTE_W +: BYTE_W] == '0);
    end

endmodule

bind tsi_switch_core tsi_switch_chk #(
    .STREAMS (STREAMS),
    .CHANNELS(CHANNELS),
    .CPU_DW  (CPU_DW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .tx_data   (tx_data),
    .tx_oe     (tx_oe),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .cur_slot  (cur_slot),
    .wr_bank   (wr_bank)
);

// File: tb/tb_tsi_switch_core.sv
module tb_tsi_switch_core;

    localparam int ST = 4;
    localparam int CH = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_sync = 1'b0;
    logic [31:0] rx_data = '0;
    logic [31:0] tx_data;
    logic [3:0]  tx_oe;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [8:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;

    int checks = 0;
    int failures = 0;
    int cur_fr = 0;
    int cur_slot = 0;
    bit started = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tsi_switch_core #(.STREAMS(ST), .CHANNELS(CH), .CPU_DW(16)) dut (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .rx_data(rx_data),
        .tx_data(tx_data), .tx_oe(tx_oe), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [7:0] pat(int s, int c, int f);
        return 8'(((s * 32 + c) ^ (f * 29)) & 255);
    endfunction

    function automatic logic [8:0] a_cm(int o, int c);
        return {2'b01, 2'(o), 5'(c)};
    endfunction
    function automatic logic [8:0] a_dm(int s, int c);
        return {2'b10, 2'(s), 5'(c)};
    endfunction
    function automatic logic [8:0] a_reg(int i);
        return {2'b00, 7'(i)};
    endfunction
    function automatic logic [15:0] w_conn(int s, int c);
        return {9'b0, 2'(s), 5'(c)};
    endfunction
    localparam logic [15:0] W_MSG  = 16'h0400;
    localparam logic [15:0] W_HIZ  = 16'h0200;
    localparam logic [15:0] W_ONES = 16'h0100;

    // frame driver: one slot per clock, inputs change on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (started) begin
                    cur_slot++;
                    if (cur_slot == CH) begin
                        cur_slot = 0;
                        cur_fr++;
                    end
                end
                started = 1;
                frame_sync = (cur_slot == 0);
                for (int s = 0; s < ST; s++)
                    rx_data[s*8 +: 8] = pat(s, cur_slot, cur_fr);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (frame %0d slot %0d)", tag, act, exp, cur_fr, cur_slot);
        end
    endtask

    task automatic chk_out(string tag, int o, logic oe, logic [7:0] d);
        chk(tag, {23'b0, tx_oe[o], tx_data[o*8 +: 8]}, {23'b0, oe, d});
    endtask

    task automatic wait_slot(int f, int s);
        do begin
            @(posedge clk);
            #5;
        end while (!(cur_fr == f && cur_slot == s));
    endtask

    task automatic cpu_write(logic [8:0] a, logic [15:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic cpu_read(logic [8:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        @(negedge clk);
        cpu_req = 0;
        d = cpu_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] rd;
        @(posedge clk); #5;
        chk("R1 oe after reset", {28'b0, tx_oe}, 32'h0);
        chk("R1 data after reset", tx_data, 32'h0);
        chk("R1 rdata after reset", {16'b0, cpu_rdata}, 32'h0);
        wait_slot(1, 3);
        chk("R1 released in frame 1", {28'b0, tx_oe}, 32'h0);
        cpu_read(a_cm(2, 9), rd);
        chk("R1 R9 reset word readback", {16'b0, rd}, {16'b0, W_HIZ});
    endtask

    task automatic t_connect();
        wait_slot(2, 4);
        cpu_write(a_cm(0, 3),  w_conn(2, 20));
        cpu_write(a_cm(1, 20), w_conn(0, 3));
        cpu_write(a_cm(2, 0),  w_conn(3, 31));
        cpu_write(a_cm(3, 31), w_conn(1, 0));
        for (int e = 3; e <= 4; e++) begin
            wait_slot(e, 0);
            chk_out("R2 R4 slot0 from end slot", 2, 1'b1, pat(3, 31, e - 2));
            wait_slot(e, 3);
            chk_out("R3 R4 later source", 0, 1'b1, pat(2, 20, e - 2));
            chk_out("R7 untouched slot released", 1, 1'b0, 8'h00);
            wait_slot(e, 20);
            chk_out("R3 R4 earlier source", 1, 1'b1, pat(0, 3, e - 2));
            wait_slot(e, 31);
            chk_out("R2 R4 last slot from slot0", 3, 1'b1, pat(1, 0, e - 2));
        end
    endtask

    task automatic t_message();
        wait_slot(5, 4);
        cpu_write(a_cm(1, 5), W_MSG | 16'h003C);
        cpu_write(a_cm(0, 5), W_MSG | 16'h00C3);
        wait_slot(6, 5);
        chk_out("R5 constant byte s1", 1, 1'b1, 8'h3C);
        chk_out("R5 constant byte s0", 0, 1'b1, 8'hC3);
    endtask

    task automatic t_priority();
        wait_slot(7, 4);
        cpu_write(a_cm(0, 9), W_ONES | w_conn(1, 1));
        cpu_write(a_cm(1, 9), W_HIZ | W_MSG | 16'h0077);
        cpu_write(a_cm(2, 9), W_ONES | W_MSG | 16'h0012);
        cpu_write(a_cm(3, 9), W_HIZ | W_ONES);
        wait_slot(8, 9);
        chk_out("R6 ones over selected", 0, 1'b1, 8'hFF);
        chk_out("R7 release over constant", 1, 1'b0, 8'h00);
        chk_out("R6 ones over constant", 2, 1'b1, 8'hFF);
        chk_out("R7 release over ones", 3, 1'b0, 8'h00);
    endtask

    task automatic t_boundary();
        logic [15:0] rd;
        wait_slot(9, 4);
        cpu_write(a_cm(2, 20), W_MSG | 16'h0011);
        wait_slot(10, 4);
        cpu_write(a_cm(2, 20), W_MSG | 16'h0022);
        cpu_read(a_cm(2, 20), rd);
        chk("R9 readback before effect", {16'b0, rd}, {16'b0, W_MSG | 16'h0022});
        wait_slot(10, 20);
        chk_out("R8 old word rest of frame", 2, 1'b1, 8'h11);
        wait_slot(11, 20);
        chk_out("R8 new word next frame", 2, 1'b1, 8'h22);
    endtask

    task automatic t_monitor();
        logic [15:0] rd;
        wait_slot(12, 4);
        cpu_read(a_dm(1, 9), rd);
        chk("R10 previous frame byte", {16'b0, rd}, {24'b0, pat(1, 9, 11)});
        cpu_write(a_dm(1, 9), 16'h0000);
        cpu_read(a_dm(1, 9), rd);
        chk("R10 data space write ignored", {16'b0, rd}, {24'b0, pat(1, 9, 11)});
    endtask

    task automatic t_fill();
        logic [15:0] rd;
        wait_slot(13, 4);
        cpu_write(a_reg(0), W_MSG | 16'h005A);
        cpu_read(a_reg(0), rd);
        chk("R11 pattern readback", {16'b0, rd}, {16'b0, W_MSG | 16'h005A});
        cpu_write(a_reg(1), 16'h0001);
        cpu_read(a_cm(3, 17), rd);
        chk("R11 filled word readback", {16'b0, rd}, {16'b0, W_MSG | 16'h005A});
        cpu_read(a_reg(1), rd);
        chk("R11 trigger reads zero", {16'b0, rd}, 32'h0);
        wait_slot(13, 20);
        chk_out("R8 fill waits for boundary", 1, 1'b1, pat(0, 3, 11));
        wait_slot(14, 2);
        for (int o = 0; o < ST; o++)
            chk_out("R11 filled output", o, 1'b1, 8'h5A);
        wait_slot(14, 31);
        for (int o = 0; o < ST; o++)
            chk_out("R11 filled output last slot", o, 1'b1, 8'h5A);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #3 rst = 0;
        t_reset();
        t_connect();
        t_message();
        t_priority();
        t_boundary();
        t_monitor();
        t_fill();
        report();
    end

endmodule